// File: doc/BRIEF.md
# UART Loopback Diagnostic Switch

This block sits between a single UART channel's core logic and the pads of that channel. It supports on-board self-test. In normal operation it passes signals straight through. The transmit bit goes to the transmit pad. The receive pad and the four active-low modem-status pads are brought into the clock domain through a reset-initialised synchronizer. They then reach the core, with the status lines converted to active-high. The request-to-send and data-terminal-ready control bits leave on their own active-low pads.

When the loopback control bit of the modem-control byte is set, the switch isolates the channel from the outside world. The core's own serial output is fed back as its receive input in the same cycle. The four status inputs the core sees are each driven from one control bit. All external outputs are parked at their inactive level, so a self-test never disturbs the line or the modem. The pad synchronizer keeps sampling while loopback is active. Leaving loopback therefore shows the current pad state at once, with no refill delay.

Top module: `uart_lpbk_switch`

## Requirements
- R1: Bit 4 of `mcr_bits` selects the mode: 1 is loopback, 0 is normal. It takes effect combinationally, in the same cycle.
- R2: In normal mode `txd_pin` equals `core_txd` in the same cycle.
- R3: In normal mode `core_rxd` equals the value `rxd_pin` held SYNC_STAGES rising clock edges earlier (default 2).
- R4: In normal mode `core_status` is the bitwise inverse of the status pads, delayed SYNC_STAGES edges. The bit order is bit 0 CTS, bit 1 DSR, bit 2 RI, bit 3 DCD.
- R5: In normal mode `rts_n_pin` is the inverse of `mcr_bits[1]` and `dtr_n_pin` is the inverse of `mcr_bits[0]`, combinationally.
- R6: In loopback mode `core_rxd` equals `core_txd` in the same cycle, and `rxd_pin` has no effect on it.
- R7: In loopback mode `txd_pin` is held at mark level (1).
- R8: In loopback mode `rts_n_pin` and `dtr_n_pin` are both held at 1 (inactive).
- R9: In loopback mode `core_status` is {mcr_bits[3], mcr_bits[2], mcr_bits[0], mcr_bits[1]}: CTS from bit 1, DSR from bit 0, RI from bit 2, DCD from bit 3. The status pads have no effect on it.
- R10: While `rst_n` is low in normal mode, `core_rxd` is 1 and `core_status` is 0.
- R11: In the first cycle after leaving loopback, `core_rxd` and `core_status` already reflect the pad values sampled during the last SYNC_STAGES edges of loopback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized internally |
| core_txd | input | 1 | Serial output of the UART transmitter |
| txd_pin | output | 1 | Transmit pad |
| rxd_pin | input | 1 | Receive pad |
| core_rxd | output | 1 | Serial input to the UART receiver |
| cts_n_pin | input | 1 | Clear-to-send pad, active low |
| dsr_n_pin | input | 1 | Data-set-ready pad, active low |
| ri_n_pin | input | 1 | Ring-indicator pad, active low |
| dcd_n_pin | input | 1 | Carrier-detect pad, active low |
| mcr_bits | input | 5 | Modem-control byte: bit 0 DTR, bit 1 RTS, bit 2 and bit 3 loopback sources for RI and DCD, bit 4 loopback enable |
| rts_n_pin | output | 1 | Request-to-send pad, active low |
| dtr_n_pin | output | 1 | Data-terminal-ready pad, active low |
| core_status | output | 4 | Active-high status to the core: bit 0 CTS, 1 DSR, 2 RI, 3 DCD |

## Verification
A stage of the pad synchronizer that was mis-wired or mis-reset would show on `core_rxd` or `core_status` exactly SYNC_STAGES edges after the pad change. The faulty value would differ from the delayed pad history on that one cycle.

A wrong cross-wiring of the control bits in loopback, or a leak of pad state through the mode select, is visible combinationally in the same cycle that `mcr_bits` or a pad changes. Because the synchronizer runs during loopback, a stale pipeline would appear on the first cycle after loopback ends. The bench therefore compares every output on every clock against a delayed-history model.

// File: rtl/lbk_pkg.sv
package lbk_pkg;
  // Field positions inside the modem-control byte
  localparam int unsigned MCR_W      = 5;
  localparam int unsigned MCR_DTR    = 0;
  localparam int unsigned MCR_RTS    = 1;
  localparam int unsigned MCR_AUX_RI = 2;
  localparam int unsigned MCR_AUX_CD = 3;
  localparam int unsigned MCR_LOOP   = 4;

  // Status lines as seen by the core (active high)
  typedef struct packed {
    logic dcd;
    logic ri;
    logic dsr;
    logic cts;
  } stat_t;

  localparam int unsigned STAT_W = $bits(stat_t);
  // Pad bundle: status pads plus receive pad on top
  localparam int unsigned PAD_W  = STAT_W + 1;
endpackage

// File: rtl/lbk_rst_sync.sv
module lbk_rst_sync #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  localparam int unsigned D = (DEPTH < 1) ? 1 : DEPTH;

  logic [D-1:0] chain_q;
  logic [D-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[D-2 >= 0 ? D-2 : 0 : 0], 1'b1};
    if (D == 1) chain_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[D-1];
endmodule

// File: rtl/lbk_sync.sv
module lbk_sync #(
  parameter int unsigned W         = 5,
  parameter int unsigned STAGES    = 2,
  parameter logic [W-1:0] RESET_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q = d;
    end else begin : g_chain
      logic [W-1:0] stage_q [STAGES];
      logic [W-1:0] stage_d [STAGES];

      always_comb begin
        stage_d[0] = d;
        for (int i = 1; i < int'(STAGES); i++) stage_d[i] = stage_q[i-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < int'(STAGES); i++) stage_q[i] <= RESET_VAL;
        end else begin
          for (int i = 0; i < int'(STAGES); i++) stage_q[i] <= stage_d[i];
        end
      end

      assign q = stage_q[STAGES-1];

      // R3/R4: first stage captures the pad bundle one edge later
      p_first_stage_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> stage_q[0] == $past(d));

      for (genvar s = 1; s < STAGES; s++) begin : g_chk
        // R4: each stage copies its predecessor one edge later
        p_stage_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
          $past(rst_n) |-> stage_q[s] == $past(stage_q[s-1]));
      end
    end
  endgenerate
endmodule

// File: rtl/lbk_core_select.sv
module lbk_core_select
  import lbk_pkg::*;
(
  input  logic             loop_en,
  input  logic [MCR_W-1:0] mcr,
  input  logic             core_txd,
  input  logic [PAD_W-1:0] pads_sync,
  output logic             core_rxd,
  output stat_t            core_stat
);
  stat_t pad_stat;
  stat_t loop_stat;

  always_comb begin
    // pads are active low; convert to active-high status
    pad_stat      = stat_t'(~pads_sync[STAT_W-1:0]);
    loop_stat.cts = mcr[MCR_RTS];
    loop_stat.dsr = mcr[MCR_DTR];
    loop_stat.ri  = mcr[MCR_AUX_RI];
    loop_stat.dcd = mcr[MCR_AUX_CD];
    if (loop_en) begin
      core_rxd  = core_txd;
      core_stat = loop_stat;
    end else begin
      core_rxd  = pads_sync[PAD_W-1];
      core_stat = pad_stat;
    end
  end
endmodule

// File: rtl/lbk_pin_drv.sv
module lbk_pin_drv
  import lbk_pkg::*;
(
  input  logic loop_en,
  input  logic core_txd,
  input  logic rts_req,
  input  logic dtr_req,
  output logic txd_pin,
  output logic rts_n_pin,
  output logic dtr_n_pin
);
  always_comb begin
    if (loop_en) begin
      txd_pin   = 1'b1;
      rts_n_pin = 1'b1;
      dtr_n_pin = 1'b1;
    end else begin
      txd_pin   = core_txd;
      rts_n_pin = ~rts_req;
      dtr_n_pin = ~dtr_req;
    end
  end
endmodule

// File: rtl/uart_lpbk_switch.sv
module uart_lpbk_switch
  import lbk_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             core_txd,
  output logic             txd_pin,
  input  logic             rxd_pin,
  output logic             core_rxd,
  input  logic             cts_n_pin,
  input  logic             dsr_n_pin,
  input  logic             ri_n_pin,
  input  logic             dcd_n_pin,
  input  logic [4:0]       mcr_bits,
  output logic             rts_n_pin,
  output logic             dtr_n_pin,
  output logic [3:0]       core_status
);
  logic             rst_n_int;
  logic             loop_en;
  logic [PAD_W-1:0] pads_raw;
  logic [PAD_W-1:0] pads_sync;
  stat_t            stat_sel;

  assign loop_en  = mcr_bits[MCR_LOOP];
  assign pads_raw = {rxd_pin, dcd_n_pin, ri_n_pin, dsr_n_pin, cts_n_pin};

  lbk_rst_sync #(.DEPTH(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  lbk_sync #(.W(PAD_W), .STAGES(SYNC_STAGES), .RESET_VAL('1)) u_pad_sync (
    .clk   (clk),
    .rst_n (rst_n_int),
    .d     (pads_raw),
    .q     (pads_sync)
  );

  lbk_core_select u_sel (
    .loop_en   (loop_en),
    .mcr       (mcr_bits),
    .core_txd  (core_txd),
    .pads_sync (pads_sync),
    .core_rxd  (core_rxd),
    .core_stat (stat_sel)
  );

  assign core_status = stat_sel;

  lbk_pin_drv u_drv (
    .loop_en   (loop_en),
    .core_txd  (core_txd),
    .rts_req   (mcr_bits[MCR_RTS]),
    .dtr_req   (mcr_bits[MCR_DTR]),
    .txd_pin   (txd_pin),
    .rts_n_pin (rts_n_pin),
    .dtr_n_pin (dtr_n_pin)
  );

  // R6: receiver is fed from the transmitter while looping back
  p_rx_loop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mcr_bits[4] |-> core_rxd == core_txd);

  // R7/R8: all outgoing pads idle during self-test
  p_pads_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mcr_bits[4] |-> (txd_pin && rts_n_pin && dtr_n_pin));

  // R9: status cross-wiring from control bits
  p_stat_cross_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mcr_bits[4] |-> core_status == {mcr_bits[3], mcr_bits[2], mcr_bits[0], mcr_bits[1]});

  // R4: normal mode shows the synchronized pads, inverted
  p_stat_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mcr_bits[4] |-> core_status == ~pads_sync[3:0]);

  // R2/R5: normal mode drives pads from the core and control bits
  p_pads_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mcr_bits[4] |-> (txd_pin == core_txd && rts_n_pin == !mcr_bits[1]
                      && dtr_n_pin == !mcr_bits[0]));
endmodule

// File: tb/uart_lpbk_switch_tb.sv
module uart_lpbk_switch_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       core_txd, rxd_pin;
  logic       cts_n, dsr_n, ri_n, dcd_n;
  logic [4:0] mcr;
  logic       txd_pin, core_rxd, rts_n, dtr_n;
  logic [3:0] core_status;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  uart_lpbk_switch #(.SYNC_STAGES(2), .RST_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .core_txd(core_txd), .txd_pin(txd_pin),
    .rxd_pin(rxd_pin), .core_rxd(core_rxd), .cts_n_pin(cts_n),
    .dsr_n_pin(dsr_n), .ri_n_pin(ri_n), .dcd_n_pin(dcd_n),
    .mcr_bits(mcr), .rts_n_pin(rts_n), .dtr_n_pin(dtr_n),
    .core_status(core_status)
  );

  // Reference: pad history two edges deep, {rxd, dcd_n, ri_n, dsr_n, cts_n}
  logic [4:0] hist1, hist2;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist1 <= 5'h1f;
      hist2 <= 5'h1f;
    end else begin
      hist1 <= {rxd_pin, dcd_n, ri_n, dsr_n, cts_n};
      hist2 <= hist1;
    end
  end

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare all outputs against the reference for the current mode
  task automatic compare_all(input bit after_loop);
    logic [3:0] e_stat;
    if (mcr[4]) begin
      // R1: bit 4 set selects loopback
      chk("R6 rx loop", {3'b0, core_rxd}, {3'b0, core_txd});
      chk("R7 tx idle", {3'b0, txd_pin}, 4'h1);
      chk("R8 ctl idle", {2'b0, rts_n, dtr_n}, 4'h3);
      chk("R9 status cross", core_status, {mcr[3], mcr[2], mcr[0], mcr[1]});
    end else begin
      e_stat = ~hist2[3:0];
      // R1: bit 4 clear selects normal mode
      chk("R2 tx pass", {3'b0, txd_pin}, {3'b0, core_txd});
      chk(after_loop ? "R11 rx resume" : "R3 rx sync", {3'b0, core_rxd}, {3'b0, hist2[4]});
      chk(after_loop ? "R11 status resume" : "R4 status sync", core_status, e_stat);
      chk("R5 ctl pads", {2'b0, rts_n, dtr_n}, {2'b0, ~mcr[1], ~mcr[0]});
    end
  endtask

  task automatic drive_rand(input bit force_loop, input bit loop_val);
    logic [31:0] r;
    r = $urandom;
    core_txd = r[0];
    rxd_pin  = r[1];
    {dcd_n, ri_n, dsr_n, cts_n} = r[5:2];
    mcr[3:0] = r[9:6];
    mcr[4]   = force_loop ? loop_val : r[10];
  endtask

  initial begin
    rst_n = 1'b0;
    core_txd = 1'b1; rxd_pin = 1'b0;
    {dcd_n, ri_n, dsr_n, cts_n} = 4'h0;
    mcr = 5'h00;
    // R10: pads active during reset must not reach the core
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R10 rst rxd", {3'b0, core_rxd}, 4'h1);
      chk("R10 rst status", core_status, 4'h0);
    end
    rxd_pin = 1'b1;
    {dcd_n, ri_n, dsr_n, cts_n} = 4'hf;
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      compare_all(1'b0);
    end
    // Free-running random traffic, mode changing at random
    for (int i = 0; i < 400; i++) begin
      drive_rand(1'b0, 1'b0);
      @(negedge clk);
      compare_all(1'b0);
    end
    // Long loopback stretches with busy pads, then exit (R11)
    for (int blk = 0; blk < 20; blk++) begin
      for (int i = 0; i < 6; i++) begin
        drive_rand(1'b1, 1'b1);
        @(negedge clk);
        compare_all(1'b0);
      end
      drive_rand(1'b1, 1'b0);
      @(negedge clk);
      compare_all(1'b1);
      for (int i = 0; i < 4; i++) begin
        drive_rand(1'b1, 1'b0);
        @(negedge clk);
        compare_all(1'b0);
      end
    end
    // Each control bit alone in loopback (R9 bit mapping)
    for (int b = 0; b < 4; b++) begin
      mcr = 5'h10 | (5'h1 << b);
      {dcd_n, ri_n, dsr_n, cts_n} = 4'h0;
      @(negedge clk);
      compare_all(1'b0);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(50000 * 10);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule